// File: doc/BRIEF.md
# Programmable Chip-Select Channel with Wait-State Acknowledge

This block is one chip-select channel on a 24-bit address bus. It samples the bus when the active-low address strobe is first seen at a clock edge. It compares the upper address bits, from bit 13 up, against a programmed base value. Each of those bits can be taken out of the compare by its own mask bit, and the read/write line can optionally qualify the match. On a hit the channel drives its active-low chip select for the rest of the bus cycle.

The bus cycle is ended in one of two ways. The channel can count a programmed number of wait states in clock cycles and then drive the active-low data-acknowledge itself, with an output enable for the shared bidirectional pad. Or, for the reserved all-ones wait code, it leaves its pad driver off so that an external device terminates the cycle. An alternate-cycle input doubles the wait count.

Two configuration words are loaded through a simple write port, one for the base and one for the options. The reset values let a boot channel select the memory that holds the reset vector.

Top module: `csel_channel`

## Requirements
- R1: After reset `cs_n` and `dtack_out_n` are 1 and `dtack_oe` is 0. With the default parameters, the boot channel then selects every read and write with address below 0x002000 and no address at or above it.
- R2: Option word bits [15:5] hold the mask for address bits 23..13 (bit 5 pairs with address bit 13). A mask bit of 0 makes its address bit a don't-care; a mask bit of 1 requires the bus bit to equal base word bits [15:5] at the same position.
- R3: Option word bit 1 is the read/write qualifier. At 0 the channel selects both reads (`bus_rw`=1) and writes (`bus_rw`=0). At 1 it selects only when `bus_rw` equals base word bit 1.
- R4: Base word bit 0 enables the channel. When it is 0, `cs_n` never asserts.
- R5: Option word bits [4:2] hold the wait code N. For N from 0 to 6, `dtack_oe` is 1 for the whole selected cycle. `dtack_out_n` falls N+1 clock edges after the edge at which `cs_n` falls, and it stays low while the strobe is held.
- R6: When `alt_mode` is 1 at the edge that starts the cycle, the wait count is 2N, so the acknowledge falls 2N+1 edges after `cs_n`.
- R7: Wait code 7 selects external termination. `dtack_oe` stays 0 and `dtack_out_n` stays 1 for the whole cycle, and `cs_n` stays low until the strobe negates, however long that takes.
- R8: At the first edge that samples `bus_as_n` high, `cs_n`, `dtack_out_n` and `dtack_oe` all return to idle. If the strobe negates before the count expires, no acknowledge is produced.
- R9: The decision to select is taken only at the edge that first samples the strobe low. Address changes later in the same strobe neither drop nor create a selection.
- R10: After reset the wait code is 6, giving an acknowledge 7 edges after `cs_n`, or 13 edges with `alt_mode` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; wait states count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes the base word, 1 writes the option word |
| cfg_wdata | input | 16 | Configuration write data |
| bus_addr | input | 24 | Bus address |
| bus_rw | input | 1 | 1 for a read, 0 for a write |
| bus_as_n | input | 1 | Active-low address strobe |
| alt_mode | input | 1 | Alternate cycle type, doubles the wait count |
| cs_n | output | 1 | Active-low chip select |
| dtack_out_n | output | 1 | Active-low acknowledge value for the pad |
| dtack_oe | output | 1 | Pad output enable for the acknowledge |

## Verification
The strobe release and the expiry of the wait counter can land on the same clock edge. The bench provokes this with wait code 3 and a strobe held low for exactly four sampled edges, so the negation is seen at the edge where the acknowledge would otherwise be set. It judges the result at the ports: the chip select must have been seen low, the acknowledge must never fall, and both must be idle one edge after the release. A second collision, an address change arriving while a cycle is being decided, is exercised by moving the address in both directions in the middle of a strobe.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned CS_ADDR_W  = 24;
  localparam int unsigned CS_BLK_LSB = 13;
  localparam int unsigned CS_WS_W    = 3;
  localparam int unsigned CS_REG_W   = 16;
  localparam int unsigned CS_SYNC_N  = 2;

  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_OPT  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_pkg::*;
#(
  parameter int unsigned MASK_W    = 11,
  parameter int unsigned WS_W      = 3,
  parameter int unsigned REG_W     = 16,
  parameter logic [MASK_W-1:0] RST_BASE = '0,
  parameter logic        RST_VALID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [MASK_W-1:0] base_addr,
  output logic              base_rw,
  output logic              base_valid,
  output logic [MASK_W-1:0] opt_mask,
  output logic              opt_mrw,
  output logic [WS_W-1:0]   opt_ws
);
  localparam int unsigned FLD_LO = REG_W - MASK_W;
  localparam logic [WS_W-1:0] RST_WS = {{(WS_W-1){1'b1}}, 1'b0};

  logic              base_en, opt_en;
  logic [MASK_W-1:0] base_addr_d, opt_mask_d;
  logic              base_rw_d, base_valid_d, opt_mrw_d;
  logic [WS_W-1:0]   opt_ws_d;

  // next-state: decode the target word and slice the fields
  always_comb begin
    base_en      = cfg_we & (cfg_sel == SEL_BASE);
    opt_en       = cfg_we & (cfg_sel == SEL_OPT);
    base_addr_d  = cfg_wdata[REG_W-1:FLD_LO];
    base_rw_d    = cfg_wdata[1];
    base_valid_d = cfg_wdata[0];
    opt_mask_d   = cfg_wdata[REG_W-1:FLD_LO];
    opt_ws_d     = cfg_wdata[WS_W+1:2];
    opt_mrw_d    = cfg_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr  <= RST_BASE;
      base_rw    <= 1'b1;
      base_valid <= RST_VALID;
      opt_mask   <= '1;
      opt_mrw    <= 1'b0;
      opt_ws     <= RST_WS;
    end else begin
      if (base_en) begin
        base_addr  <= base_addr_d;
        base_rw    <= base_rw_d;
        base_valid <= base_valid_d;
      end
      if (opt_en) begin
        opt_mask <= opt_mask_d;
        opt_mrw  <= opt_mrw_d;
        opt_ws   <= opt_ws_d;
      end
    end
  end
endmodule

// File: rtl/csel_match.sv
module csel_match #(
  parameter int unsigned MASK_W = 11
) (
  input  logic [MASK_W-1:0] bus_hi,
  input  logic              bus_rw,
  input  logic [MASK_W-1:0] base_addr,
  input  logic              base_rw,
  input  logic              base_valid,
  input  logic [MASK_W-1:0] opt_mask,
  input  logic              opt_mrw,
  output logic              hit
);
  logic [MASK_W-1:0] bit_ok;
  logic              rw_ok;

  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    assign bit_ok[i] = ~opt_mask[i] | (bus_hi[i] ~^ base_addr[i]);
  end

  always_comb begin
    rw_ok = ~opt_mrw | (bus_rw ~^ base_rw);
    hit   = base_valid & rw_ok & (&bit_ok);
  end
endmodule

// File: rtl/csel_wait_ctrl.sv
module csel_wait_ctrl #(
  parameter int unsigned WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_n,
  input  logic            hit,
  input  logic [WS_W-1:0] ws_code,
  input  logic            alt,
  output logic            cs_n,
  output logic            dtack_n,
  output logic            dtack_oe
);
  localparam int unsigned CNT_W = WS_W + 1;
  localparam logic [WS_W-1:0] EXT_CODE = '1;

  logic             seen_q, seen_d;
  logic             act_q, act_d;
  logic             ext_q, ext_d;
  logic             ack_q, ack_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start, cnt_en, cnt_en_any;

  always_comb begin
    start      = ~as_n & ~seen_q & hit;
    cnt_en     = ~as_n & act_q & ~ext_q & (cnt_q != '0);
    cnt_en_any = as_n | start | cnt_en;
    seen_d     = ~as_n;
    act_d      = act_q;
    ext_d      = ext_q;
    ack_d      = ack_q;
    cnt_d      = cnt_q;
    if (as_n) begin
      act_d = 1'b0;
      ext_d = 1'b0;
      ack_d = 1'b0;
      cnt_d = '0;
    end else if (start) begin
      act_d = 1'b1;
      ext_d = (ws_code == EXT_CODE);
      cnt_d = alt ? {ws_code, 1'b0} : {1'b0, ws_code};
    end else if (cnt_en) begin
      cnt_d = cnt_q - 1'b1;
    end else if (act_q & ~ext_q) begin
      ack_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      act_q  <= 1'b0;
      ext_q  <= 1'b0;
      ack_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      seen_q <= seen_d;
      act_q  <= act_d;
      ext_q  <= ext_d;
      ack_q  <= ack_d;
      if (cnt_en_any) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign cs_n     = ~act_q;
  assign dtack_oe = act_q & ~ext_q;
  assign dtack_n  = ~ack_q;
endmodule

// File: rtl/csel_channel.sv
module csel_channel
  import csel_pkg::*;
#(
  parameter int unsigned ADDR_W    = CS_ADDR_W,
  parameter int unsigned BLK_LSB   = CS_BLK_LSB,
  parameter int unsigned WS_W      = CS_WS_W,
  parameter int unsigned REG_W     = CS_REG_W,
  parameter int unsigned SYNC_N    = CS_SYNC_N,
  parameter int unsigned BOOT_BASE = 0,
  parameter logic        BOOT_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rw,
  input  logic              bus_as_n,
  input  logic              alt_mode,
  output logic              cs_n,
  output logic              dtack_out_n,
  output logic              dtack_oe
);
  localparam int unsigned MASK_W = ADDR_W - BLK_LSB;
  localparam logic [MASK_W-1:0] RST_BASE = BOOT_BASE[MASK_W-1:0];

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;
  logic [MASK_W-1:0] base_addr, opt_mask;
  logic              base_rw, base_valid, opt_mrw, hit;
  logic [WS_W-1:0]   opt_ws;
  logic              unused_low;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_int_n  = rst_pipe[SYNC_N-1];
  assign unused_low = ^bus_addr[BLK_LSB-1:0];

  csel_cfg_regs #(
    .MASK_W(MASK_W), .WS_W(WS_W), .REG_W(REG_W),
    .RST_BASE(RST_BASE), .RST_VALID(BOOT_EN)
  ) i_regs (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_addr(base_addr), .base_rw(base_rw), .base_valid(base_valid),
    .opt_mask(opt_mask), .opt_mrw(opt_mrw), .opt_ws(opt_ws)
  );

  csel_match #(.MASK_W(MASK_W)) i_match (
    .bus_hi(bus_addr[ADDR_W-1:BLK_LSB]), .bus_rw(bus_rw),
    .base_addr(base_addr), .base_rw(base_rw), .base_valid(base_valid),
    .opt_mask(opt_mask), .opt_mrw(opt_mrw), .hit(hit)
  );

  csel_wait_ctrl #(.WS_W(WS_W)) i_wait (
    .clk(clk), .rst_n(rst_int_n),
    .as_n(bus_as_n), .hit(hit), .ws_code(opt_ws), .alt(alt_mode),
    .cs_n(cs_n), .dtack_n(dtack_out_n), .dtack_oe(dtack_oe)
  );
endmodule

// File: rtl/csel_channel_chk.sv
module csel_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_as_n,
  input logic cs_n,
  input logic dtack_out_n,
  input logic dtack_oe
);
  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_n |=> (cs_n && dtack_out_n && !dtack_oe));

  // R7
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dtack_oe |-> !cs_n);

  // R5
  dtack_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_out_n |-> dtack_oe);

  // R5
  dtack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_out_n && !bus_as_n) |=> !dtack_out_n);

  // R9
  cs_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!bus_as_n));

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (cs_n && dtack_out_n && !dtack_oe);
    end
  end
endmodule

bind csel_channel csel_channel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n),
  .cs_n(cs_n), .dtack_out_n(dtack_out_n), .dtack_oe(dtack_oe)
);

// File: tb/test_csel_channel.sv
module test_csel_channel;
  localparam int CLK_PER = 10;

  logic        clk, rst_n, cfg_we, cfg_sel;
  logic [15:0] cfg_wdata;
  logic [23:0] bus_addr;
  logic        bus_rw, bus_as_n, alt_mode;
  logic        cs_n, dtack_out_n, dtack_oe;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    bit    hit;
    int    lat;
    bit    ext;
    string req;
  } exp_t;
  exp_t sbq[$];

  csel_channel i_csel_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_as_n(bus_as_n), .alt_mode(alt_mode), .cs_n(cs_n),
    .dtack_out_n(dtack_out_n), .dtack_oe(dtack_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  // driver: push expectation, then run one strobe
  task automatic bus_cycle(input logic [23:0] a, input logic rw, input logic alt,
                           input logic [23:0] a2, input int hold_ovr,
                           input bit hit, input int lat, input bit ext, input string req);
    exp_t e;
    int hold;
    e.hit = hit; e.lat = lat; e.ext = ext; e.req = req;
    sbq.push_back(e);
    hold = (hold_ovr > 0) ? hold_ovr : ((hit && !ext) ? lat + 4 : 16);
    @(posedge clk); #2;
    bus_addr = a; bus_rw = rw; alt_mode = alt; bus_as_n = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #2;
      if (i == 1) bus_addr = a2;
    end
    bus_as_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  // monitor: measure each strobe at the falling edge and compare
  bit   in_cyc = 0;
  bit   tail = 0;
  int   k, cs_k, dt_k;
  bit   oe_any;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_as_n) begin
        if (!in_cyc) begin
          in_cyc = 1; k = 0; cs_k = -1; dt_k = -1; oe_any = 0;
          if (sbq.size() == 0) begin
            check(0, "scoreboard", 0, 1);
            cur.hit = 0; cur.lat = -1; cur.ext = 0; cur.req = "none";
          end else begin
            cur = sbq.pop_front();
          end
        end
        k++;
        if (!cs_n && cs_k < 0) cs_k = k;
        if (dtack_oe) oe_any = 1;
        if (dtack_oe && !dtack_out_n && dt_k < 0) dt_k = k;
      end else if (in_cyc) begin
        if (!tail) begin
          check(cs_n == !cur.hit, {cur.req, " select held to release"}, int'(cs_n), int'(!cur.hit));
          tail = 1;
        end else begin
          check(cs_k == (cur.hit ? 2 : -1), {cur.req, " select edge"}, cs_k, cur.hit ? 2 : -1);
          check(oe_any == (cur.hit && !cur.ext), {cur.req, " pad enable"}, int'(oe_any),
                int'(cur.hit && !cur.ext));
          check(((dt_k < 0) ? -1 : dt_k - 2) == cur.lat, {cur.req, " acknowledge latency"},
                (dt_k < 0) ? -1 : dt_k - 2, cur.lat);
          check(cs_n && dtack_out_n && !dtack_oe, {cur.req, " R8 idle after release"},
                int'({cs_n, dtack_out_n, dtack_oe}), 3'b110);
          in_cyc = 0; tail = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_PER * 100000);
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    bus_addr = '0; bus_rw = 1'b1; bus_as_n = 1'b1; alt_mode = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(cs_n && dtack_out_n && !dtack_oe, "R1 reset outputs",
          int'({cs_n, dtack_out_n, dtack_oe}), 3'b110);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // boot defaults
    bus_cycle(24'h000100, 1'b1, 1'b0, 24'h000100, 0, 1, 7, 0, "R1 R10 boot read");
    bus_cycle(24'h001FFE, 1'b0, 1'b1, 24'h001FFE, 0, 1, 13, 0, "R1 R10 boot write alt");
    bus_cycle(24'h002000, 1'b1, 1'b0, 24'h002000, 0, 0, -1, 0, "R1 outside block");

    // 64 KB block at 0x080000, writes only, 2 waits
    cfg_write(1'b0, 16'h0801);
    cfg_write(1'b1, 16'hFF0A);
    bus_cycle(24'h08E000, 1'b0, 1'b0, 24'h08E000, 0, 1, 3, 0, "R2 R5 masked bits");
    bus_cycle(24'h080000, 1'b1, 1'b0, 24'h080000, 0, 0, -1, 0, "R3 read refused");
    bus_cycle(24'h090000, 1'b0, 1'b0, 24'h090000, 0, 0, -1, 0, "R2 compared bit");
    bus_cycle(24'h080010, 1'b0, 1'b1, 24'h080010, 0, 1, 5, 0, "R6 doubled");

    // qualifier off, zero waits
    cfg_write(1'b1, 16'hFF00);
    bus_cycle(24'h080000, 1'b1, 1'b0, 24'h080000, 0, 1, 1, 0, "R3 R5 read zero wait");
    bus_cycle(24'h080000, 1'b0, 1'b1, 24'h080000, 0, 1, 1, 0, "R3 R6 write zero alt");

    // external termination
    cfg_write(1'b1, 16'hFF1C);
    bus_cycle(24'h080000, 1'b0, 1'b0, 24'h080000, 0, 1, -1, 1, "R7 external");
    bus_cycle(24'h080000, 1'b1, 1'b1, 24'h080000, 30, 1, -1, 1, "R7 external long");

    // sampling at the strobe, release racing the counter
    cfg_write(1'b1, 16'hFF0C);
    bus_cycle(24'h080000, 1'b1, 1'b0, 24'h100000, 0, 1, 4, 0, "R9 address leaves");
    bus_cycle(24'h100000, 1'b1, 1'b0, 24'h080000, 0, 0, -1, 0, "R9 address arrives");
    bus_cycle(24'h080000, 1'b1, 1'b0, 24'h080000, 4, 1, -1, 0, "R8 release wins");
    bus_cycle(24'h080000, 1'b1, 1'b0, 24'h080000, 0, 1, 4, 0, "R5 three waits");

    // channel disabled
    cfg_write(1'b0, 16'h0800);
    bus_cycle(24'h080000, 1'b1, 1'b0, 24'h080000, 0, 0, -1, 0, "R4 disabled");

    repeat (4) @(posedge clk);
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule